// File: doc/BRIEF.md
# Controller Command Packet Processor

This block sits behind a byte transfer engine and handles one complete host-to-device packet at a time. The bytes arrive on a valid/ready stream, with a last flag on the final byte. The first byte names the packet class. A packet in the controller-command class carries a command byte and then its argument bytes. The block checks the argument count, applies the command to its own state, and streams a reply packet back on a second valid/ready stream.

The block holds four pieces of state: a 32-bit seconds counter, an auto-poll enable, an auto-poll period in milliseconds, and a 16-bit device poll mask. The seconds counter counts from midnight on 1 January 1904 and advances from a system-clock prescaler. At reset it holds 2082844800, which is the 1970 epoch expressed on that time base. The auto-poll and mask settings leave the block as plain control pins for the peripheral poller. The power-down and system-restart commands each raise a one-cycle request pin.

Back-pressure works as follows. The input is accepted only while no earlier packet is being handled; `in_ready` falls after a last byte is accepted and rises again once the reply has fully left. On the output, a byte stays on `out_data`, with `out_last` unchanged, until `out_ready` takes it.

Top module: `cmd_packet_proc`

## Requirements
- R1: After reset, auto-poll is disabled, the mask is 0x0000, the period is RATE_INIT (default 11), the seconds counter is EPOCH_INIT (default 2082844800), `in_ready` is high and `out_valid` is low.
- R2: A byte moves in when `in_valid` and `in_ready` are both high, and `in_last` marks the end of the packet. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values. `out_last` is set on the final reply byte only.
- R3: A valid command is answered with the three bytes 0x01, 0x00 and the command, followed by any result bytes.
- R4: The known command codes are 0x01 auto-poll, 0x03 get-time, 0x09 set-time, 0x0A power-down, 0x11 restart, 0x14 set-period and 0x19 set-mask. Any other command byte gets the reply 0x02, 0x02, 0x01, command.
- R5: The argument count is the number of bytes after the command byte. A known command with the wrong count gets the reply 0x02, 0x05, 0x01, command and changes no state.
- R6: Auto-poll takes one argument. A nonzero argument enables polling and zero disables it.
- R7: Set-period takes one argument and loads the period. A zero argument is a parameter error (the R5 reply), and the period is left unchanged.
- R8: Set-mask takes two arguments. The first is the high byte of the mask and the second is the low byte.
- R9: Set-time takes four arguments, most significant first, and loads the seconds counter. Get-time takes none and returns the counter as four result bytes, most significant first.
- R10: The seconds counter advances by exactly one every TICKS_PER_SEC clock cycles. A set-time load restarts the prescaler.
- R11: Power-down and restart take no arguments. Each raises its own request pin for exactly one cycle. With any other argument count they get the R5 reply and raise no pin.
- R12: A packet whose class byte is not 0x01, or that ends before a command byte, is consumed without a reply and without any state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Packet byte offered |
| in_ready | output | 1 | Block accepts a packet byte |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Final byte of the packet |
| out_valid | output | 1 | Reply byte offered |
| out_ready | input | 1 | Downstream takes the reply byte |
| out_data | output | 8 | Reply byte |
| out_last | output | 1 | Final byte of the reply |
| poll_en | output | 1 | Auto-poll enable |
| poll_rate_ms | output | 8 | Auto-poll period in milliseconds |
| poll_mask | output | 16 | Device poll mask |
| rtc_seconds | output | 32 | Seconds since 1904-01-01 |
| pwr_down_req | output | 1 | One-cycle power-down request |
| sys_reset_req | output | 1 | One-cycle restart request |

## Verification
A wrong state register is visible on the control pins in the cycle after the command's decode cycle. It also shows up in the next get-time reply, which is checked byte for byte against a value set only a few cycles earlier. A decode fault changes the second or fourth byte of the reply, or its length, so it is caught as soon as the reply drains. A prescaler fault moves the seconds count away from the expected value within one TICKS_PER_SEC window. A missing or doubled request pulse is caught by the per-packet pulse counts.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam int ARG_MAX   = 4;
  localparam int CNT_W     = 4;
  localparam int REPLY_MAX = 8;
  localparam int IDX_W     = $clog2(REPLY_MAX);

  localparam logic [7:0] CLS_PERIPH = 8'h00;
  localparam logic [7:0] CLS_CTRL   = 8'h01;
  localparam logic [7:0] CLS_ERR    = 8'h02;
  localparam logic [7:0] CLS_TIMER  = 8'h03;
  localparam logic [7:0] CLS_POWER  = 8'h04;
  localparam logic [7:0] CLS_I2C    = 8'h05;

  localparam logic [7:0] ERR_UNKNOWN = 8'h02;
  localparam logic [7:0] ERR_BADARG  = 8'h05;

  localparam logic [7:0] OP_AUTOPOLL   = 8'h01;
  localparam logic [7:0] OP_GET_TIME   = 8'h03;
  localparam logic [7:0] OP_SET_TIME   = 8'h09;
  localparam logic [7:0] OP_POWER_DOWN = 8'h0A;
  localparam logic [7:0] OP_RESTART    = 8'h11;
  localparam logic [7:0] OP_POLL_RATE  = 8'h14;
  localparam logic [7:0] OP_DEV_MASK   = 8'h19;

  typedef struct packed {
    logic                            valid;
    logic [IDX_W-1:0]                last_idx;
    logic [REPLY_MAX-1:0][7:0]       bytes;
  } reply_t;

  typedef struct packed {
    logic        poll_we;
    logic        poll_val;
    logic        rate_we;
    logic [7:0]  rate_val;
    logic        mask_we;
    logic [15:0] mask_val;
    logic        time_we;
    logic [31:0] time_val;
    logic        pd;
    logic        rst;
  } action_t;

  typedef enum logic [1:0] {ST_RX, ST_EXEC, ST_TX} state_e;
endpackage

// File: rtl/cmd_rx_buffer.sv
module cmd_rx_buffer
  import cmd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          accept,
  input  logic                          clr,
  input  logic [7:0]                    data,
  output logic [7:0]                    cls,
  output logic [7:0]                    op,
  output logic [ARG_MAX-1:0][7:0]       args,
  output logic [CNT_W-1:0]              nbytes
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nbytes <= '0;
      cls    <= '0;
      op     <= '0;
      args   <= '0;
    end else if (clr) begin
      nbytes <= '0;
    end else if (accept) begin
      if (nbytes == CNT_W'(0)) cls <= data;
      if (nbytes == CNT_W'(1)) op  <= data;
      for (int k = 0; k < ARG_MAX; k++)
        if (nbytes == CNT_W'(k + 2)) args[k] <= data;
      if (nbytes != '1) nbytes <= nbytes + CNT_W'(1);
    end
  end
endmodule

// File: rtl/cmd_decode.sv
module cmd_decode
  import cmd_pkg::*;
(
  input  logic [7:0]              cls,
  input  logic [7:0]              op,
  input  logic [ARG_MAX-1:0][7:0] args,
  input  logic [CNT_W-1:0]        nbytes,
  input  logic [31:0]             seconds,
  output reply_t                  rep,
  output action_t                 act
);
  logic [CNT_W-1:0] argc, need;
  logic             known, bad;

  always_comb begin
    rep   = '0;
    act   = '0;
    known = 1'b1;
    need  = '0;
    argc  = nbytes - CNT_W'(2);
    case (op)
      OP_AUTOPOLL, OP_POLL_RATE: need = CNT_W'(1);
      OP_DEV_MASK:               need = CNT_W'(2);
      OP_SET_TIME:               need = CNT_W'(4);
      OP_GET_TIME, OP_POWER_DOWN, OP_RESTART: need = '0;
      default:                   known = 1'b0;
    endcase
    bad = (argc != need) || (op == OP_POLL_RATE && args[0] == 8'h00);

    if (cls == CLS_CTRL && nbytes >= CNT_W'(2)) begin
      rep.valid = 1'b1;
      if (!known || bad) begin
        rep.last_idx = IDX_W'(3);
        rep.bytes[0] = CLS_ERR;
        rep.bytes[1] = known ? ERR_BADARG : ERR_UNKNOWN;
        rep.bytes[2] = CLS_CTRL;
        rep.bytes[3] = op;
      end else begin
        rep.last_idx = IDX_W'(2);
        rep.bytes[0] = CLS_CTRL;
        rep.bytes[1] = 8'h00;
        rep.bytes[2] = op;
        case (op)
          OP_AUTOPOLL: begin
            act.poll_we  = 1'b1;
            act.poll_val = (args[0] != 8'h00);
          end
          OP_POLL_RATE: begin
            act.rate_we  = 1'b1;
            act.rate_val = args[0];
          end
          OP_DEV_MASK: begin
            act.mask_we  = 1'b1;
            act.mask_val = {args[0], args[1]};
          end
          OP_SET_TIME: begin
            act.time_we  = 1'b1;
            act.time_val = {args[0], args[1], args[2], args[3]};
          end
          OP_GET_TIME: begin
            rep.last_idx = IDX_W'(6);
            rep.bytes[3] = seconds[31:24];
            rep.bytes[4] = seconds[23:16];
            rep.bytes[5] = seconds[15:8];
            rep.bytes[6] = seconds[7:0];
          end
          OP_POWER_DOWN: act.pd  = 1'b1;
          OP_RESTART:    act.rst = 1'b1;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds #(
  parameter int unsigned TICKS = 200_000_000,
  parameter logic [31:0] INIT  = 32'd2082844800
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] load_val,
  output logic [31:0] sec
);
  localparam int PRE_W = (TICKS > 1) ? $clog2(TICKS) : 1;
  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre <= '0;
      sec <= INIT;
    end else if (load) begin
      pre <= '0;
      sec <= load_val;
    end else if (pre == PRE_W'(TICKS - 1)) begin
      pre <= '0;
      sec <= sec + 32'd1;
    end else begin
      pre <= pre + PRE_W'(1);
    end
  end

  p_sec_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (sec == $past(sec) || sec == $past(sec) + 32'd1));
endmodule

// File: rtl/reply_serializer.sv
module reply_serializer
  import cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  reply_t     rep,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last
);
  logic [REPLY_MAX-1:0][7:0] held;
  logic [IDX_W-1:0]          idx, last_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      idx       <= '0;
      last_idx  <= '0;
      held      <= '0;
    end else if (load) begin
      held      <= rep.bytes;
      last_idx  <= rep.last_idx;
      idx       <= '0;
      out_valid <= 1'b1;
    end else if (out_valid && out_ready) begin
      if (idx == last_idx) out_valid <= 1'b0;
      else                 idx <= idx + IDX_W'(1);
    end
  end

  assign out_data = held[idx];
  assign out_last = out_valid && (idx == last_idx);

  p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: rtl/cmd_packet_proc.sv
module cmd_packet_proc
  import cmd_pkg::*;
#(
  parameter int unsigned TICKS_PER_SEC = 200_000_000,
  parameter logic [31:0] EPOCH_INIT    = 32'd2082844800,
  parameter logic [7:0]  RATE_INIT     = 8'd11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        poll_en,
  output logic [7:0]  poll_rate_ms,
  output logic [15:0] poll_mask,
  output logic [31:0] rtc_seconds,
  output logic        pwr_down_req,
  output logic        sys_reset_req
);
  state_e                  state;
  logic                    accept, exec;
  logic [7:0]              cls, op;
  logic [ARG_MAX-1:0][7:0] args;
  logic [CNT_W-1:0]        nbytes;
  reply_t                  rep;
  action_t                 act;

  assign in_ready = (state == ST_RX);
  assign accept   = in_valid && in_ready;
  assign exec     = (state == ST_EXEC);

  cmd_rx_buffer u_rx (
    .clk(clk), .rst_n(rst_n), .accept(accept), .clr(exec), .data(in_data),
    .cls(cls), .op(op), .args(args), .nbytes(nbytes)
  );

  cmd_decode u_dec (
    .cls(cls), .op(op), .args(args), .nbytes(nbytes), .seconds(rtc_seconds),
    .rep(rep), .act(act)
  );

  rtc_seconds #(.TICKS(TICKS_PER_SEC), .INIT(EPOCH_INIT)) u_rtc (
    .clk(clk), .rst_n(rst_n), .load(exec && act.time_we),
    .load_val(act.time_val), .sec(rtc_seconds)
  );

  reply_serializer u_tx (
    .clk(clk), .rst_n(rst_n), .load(exec && rep.valid), .rep(rep),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_RX;
    end else begin
      case (state)
        ST_RX:   if (accept && in_last) state <= ST_EXEC;
        ST_EXEC: state <= rep.valid ? ST_TX : ST_RX;
        ST_TX:   if (out_valid && out_ready && out_last) state <= ST_RX;
        default: state <= ST_RX;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      poll_en       <= 1'b0;
      poll_rate_ms  <= RATE_INIT;
      poll_mask     <= '0;
      pwr_down_req  <= 1'b0;
      sys_reset_req <= 1'b0;
    end else begin
      pwr_down_req  <= exec && act.pd;
      sys_reset_req <= exec && act.rst;
      if (exec && act.poll_we) poll_en      <= act.poll_val;
      if (exec && act.rate_we) poll_rate_ms <= act.rate_val;
      if (exec && act.mask_we) poll_mask    <= act.mask_val;
    end
  end

  p_stall_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_last) |=> !in_ready);
  p_idle_no_reply_r12: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);
  p_pd_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down_req |=> !pwr_down_req);
  p_rst_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sys_reset_req |=> !sys_reset_req);
  p_req_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pwr_down_req && sys_reset_req));
  p_rate_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (RATE_INIT != 8'h00) |-> (poll_rate_ms != 8'h00));
endmodule

// File: tb/tb_cmd_packet_proc.sv
`timescale 1ns/1ps
module tb_cmd_packet_proc;
  localparam int TICKS = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, out_valid, out_last, poll_en, pwr_down_req, sys_reset_req;
  logic [7:0]  out_data, poll_rate_ms;
  logic [15:0] poll_mask;
  logic [31:0] rtc_seconds;

  always #2.5 clk = ~clk;

  cmd_packet_proc #(.TICKS_PER_SEC(TICKS)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .poll_en(poll_en), .poll_rate_ms(poll_rate_ms), .poll_mask(poll_mask),
    .rtc_seconds(rtc_seconds), .pwr_down_req(pwr_down_req),
    .sys_reset_req(sys_reset_req)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] pkt [16];
  int plen;
  logic [7:0] got [16];
  int gotn;
  logic [7:0] ex [8];
  int exn;
  string tag;
  bit m_en = 1'b0;
  logic [7:0] m_rate = 8'd11;
  logic [15:0] m_mask = '0;
  logic [31:0] m_time = 32'd2082844800;
  bit exact_time = 1'b1;
  bit pd_e, rs_e;
  int pd_cnt = 0, rs_cnt = 0;

  always @(negedge clk) begin
    if (pwr_down_req) pd_cnt++;
    if (sys_reset_req) rs_cnt++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  function automatic int need_of(input logic [7:0] op);
    case (op)
      8'h01, 8'h14: return 1;
      8'h19: return 2;
      8'h09: return 4;
      8'h03, 8'h0A, 8'h11: return 0;
      default: return -1;
    endcase
  endfunction

  function automatic void model();
    int argc, nd;
    logic [7:0] op;
    exn = 0; pd_e = 0; rs_e = 0;
    if (plen < 2 || pkt[0] != 8'h01) begin tag = "R12"; return; end
    op = pkt[1]; argc = plen - 2; nd = need_of(op);
    if (nd < 0) begin
      ex[0] = 8'h02; ex[1] = 8'h02; ex[2] = 8'h01; ex[3] = op; exn = 4; tag = "R4";
    end else if (argc != nd || (op == 8'h14 && pkt[2] == 8'h00)) begin
      ex[0] = 8'h02; ex[1] = 8'h05; ex[2] = 8'h01; ex[3] = op; exn = 4; tag = "R5";
    end else begin
      ex[0] = 8'h01; ex[1] = 8'h00; ex[2] = op; exn = 3; tag = "R3";
      case (op)
        8'h01: m_en = (pkt[2] != 8'h00);
        8'h14: m_rate = pkt[2];
        8'h19: m_mask = {pkt[2], pkt[3]};
        8'h09: m_time = {pkt[2], pkt[3], pkt[4], pkt[5]};
        8'h03: begin
          exn = 7; tag = "R9";
          ex[3] = m_time[31:24]; ex[4] = m_time[23:16];
          ex[5] = m_time[15:8];  ex[6] = m_time[7:0];
        end
        8'h0A: pd_e = 1;
        8'h11: rs_e = 1;
        default: ;
      endcase
    end
  endfunction

  task automatic pk(input int n, input logic [7:0] b0, b1, b2, b3, b4, b5);
    plen = n;
    pkt[0] = b0; pkt[1] = b1; pkt[2] = b2; pkt[3] = b3; pkt[4] = b4; pkt[5] = b5;
  endtask

  task automatic send();
    int i = 0;
    while (i < plen) begin
      bit acc;
      @(negedge clk);
      in_valid = 1'b1; in_data = pkt[i]; in_last = (i == plen - 1);
      acc = in_ready;
      @(posedge clk);
      if (acc) i++;
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic recv(output bit ok);
    bit lst = 1'b0;
    gotn = 0; ok = 1'b0;
    for (int t = 0; t < 200 && !lst; t++) begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      if (out_valid && out_ready) begin
        if (gotn < 16) got[gotn] = out_data;
        gotn++;
        lst = out_last;
      end
      @(posedge clk);
    end
    @(negedge clk);
    out_ready = 1'b0;
    ok = lst;
  endtask

  task automatic xact();
    int pd0, rs0, cmpn, seen;
    bit ok;
    pd0 = pd_cnt; rs0 = rs_cnt;
    model();
    send();
    if (exn > 0) begin
      recv(ok);
      chk(ok, tag, "reply ended", ok, 1);
      chk(gotn == exn, tag, "reply length", gotn, exn);
      cmpn = (exn == 7 && !exact_time) ? 3 : exn;
      for (int i = 0; i < cmpn && i < gotn; i++)
        chk(got[i] == ex[i], tag, $sformatf("reply byte %0d", i), got[i], ex[i]);
    end else begin
      seen = 0;
      for (int t = 0; t < 12; t++) begin
        @(negedge clk);
        if (out_valid) seen++;
      end
      chk(seen == 0 && in_ready, "R12", "no reply and ready again", seen, 0);
    end
    repeat (2) @(negedge clk);
    chk(pd_cnt - pd0 == int'(pd_e), "R11", "power-down pulses", pd_cnt - pd0, pd_e);
    chk(rs_cnt - rs0 == int'(rs_e), "R11", "restart pulses", rs_cnt - rs0, rs_e);
    chk(poll_en == m_en, "R6", "poll enable", poll_en, m_en);
    chk(poll_rate_ms == m_rate, "R7", "poll period", poll_rate_ms, m_rate);
    chk(poll_mask == m_mask, "R8", "poll mask", poll_mask, m_mask);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!poll_en, "R1", "poll enable at reset", poll_en, 0);
    chk(poll_mask == 16'h0, "R1", "mask at reset", poll_mask, 0);
    chk(poll_rate_ms == 8'd11, "R1", "period at reset", poll_rate_ms, 11);
    chk(rtc_seconds == 32'd2082844800, "R1", "seconds at reset", rtc_seconds, 32'd2082844800);
    chk(in_ready && !out_valid, "R1", "idle stream state", {in_ready, out_valid}, 2'b10);

    pk(2, 8'h01, 8'h77, 0, 0, 0, 0); xact();               // R4 unknown command
    pk(3, 8'h01, 8'h01, 8'h80, 0, 0, 0); xact();           // R6 enable
    pk(3, 8'h01, 8'h01, 8'h00, 0, 0, 0); xact();           // R6 disable
    pk(3, 8'h01, 8'h01, 8'h02, 0, 0, 0); xact();           // R6 nonzero enables
    pk(3, 8'h01, 8'h14, 8'h00, 0, 0, 0); xact();           // R7 zero period rejected
    pk(3, 8'h01, 8'h14, 8'd25, 0, 0, 0); xact();           // R7 load
    pk(4, 8'h01, 8'h19, 8'hA5, 8'h3C, 0, 0); xact();       // R8 mask order
    pk(3, 8'h01, 8'h19, 8'h11, 0, 0, 0); xact();           // R5 short argument list
    pk(6, 8'h01, 8'h09, 8'h12, 8'h34, 8'h56, 8'h78); xact(); // R9 set-time
    chk(rtc_seconds == 32'h12345678, "R9", "seconds after load", rtc_seconds, 32'h12345678);
    pk(2, 8'h01, 8'h03, 0, 0, 0, 0); xact();               // R9 get-time
    pk(3, 8'h01, 8'h03, 8'h00, 0, 0, 0); xact();           // R5 extra argument
    begin
      logic [31:0] s0;
      @(negedge clk); s0 = rtc_seconds;
      repeat (TICKS) @(negedge clk);
      chk(rtc_seconds == s0 + 1, "R10", "one tick", rtc_seconds, s0 + 1);
      repeat (3 * TICKS) @(negedge clk);
      chk(rtc_seconds == s0 + 4, "R10", "four ticks", rtc_seconds, s0 + 4);
    end
    pk(2, 8'h01, 8'h0A, 0, 0, 0, 0); xact();               // R11 power-down
    pk(2, 8'h01, 8'h11, 0, 0, 0, 0); xact();               // R11 restart
    pk(3, 8'h01, 8'h0A, 8'h00, 0, 0, 0); xact();           // R11 argument rejected
    pk(3, 8'h01, 8'h11, 8'h05, 0, 0, 0); xact();           // R11 argument rejected
    pk(3, 8'h00, 8'h01, 8'h80, 0, 0, 0); xact();           // R12 other class
    pk(1, 8'h01, 0, 0, 0, 0, 0); xact();                   // R12 no command byte

    exact_time = 1'b0;
    for (int n = 0; n < 300; n++) begin
      logic [7:0] ops [8];
      logic [7:0] op;
      int argc;
      ops[0] = 8'h01; ops[1] = 8'h03; ops[2] = 8'h09; ops[3] = 8'h0A;
      ops[4] = 8'h11; ops[5] = 8'h14; ops[6] = 8'h19; ops[7] = 8'($urandom);
      op = ops[$urandom % 8];
      argc = (($urandom % 2) == 0 && need_of(op) >= 0) ? need_of(op) : int'($urandom % 6);
      plen = argc + 2;
      pkt[0] = (($urandom % 8) == 0) ? 8'($urandom % 6) : 8'h01;
      pkt[1] = op;
      for (int k = 0; k < argc; k++)
        pkt[k + 2] = (($urandom % 4) == 0) ? 8'h00 : 8'($urandom);
      xact();
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule